// File: doc/BRIEF.md
# Trace Capture Gate and Trigger Sequencer

This block decides, in every clock cycle, whether the execution-trace stream of a processor is written to trace storage. In its gated mode a sub-switch controls capture. The sub-switch is built from a section flag and a qualify event. Section-on and section-off strobes set and clear the flag. The qualify event is combined with the flag by OR or by AND, as configuration selects. Two policy bits decide whether data is captured while the sub-switch is on, while it is off, in both states, or in neither. A forced-start mode bypasses the sub-switch and captures whenever the processor runs.

A trigger is taken from several sources: an execution-address hit, a hit on any of the data-compare channels, an edge on an external pin, or an event-match strobe. After the trigger, the block captures a programmed number of further cycles and then ends the trace for good. A stop caused by the sub-switch only pauses capture, while an ended trace stays ended until the block is re-armed. A forced-delay mode ignores the trigger and counts from the first captured cycle. An active-low pulse reports each trigger that is taken, and a synchronous arm/clear input prepares the block for a new run.

Top module: `trace_gate_seq`

## Requirements
- R1: The section flag is set one cycle after `sec_on_ev` and cleared one cycle after `sec_off_ev`. When both strobes arrive in the same cycle, set wins. A cleared flag comes out of reset.
- R2: The sub-switch is on when (flag OR `qual_ev`) with `comb_and`=0, and when (flag AND `qual_ev`) with `comb_and`=1.
- R3: In gated mode (`mode`=00 or 11), `cap_en` is high when `run` is high, the trace has not ended, and either the sub-switch is on with `cap_on`=1 or the sub-switch is off with `cap_off`=1.
- R4: In forced-start mode (`mode`=01), `cap_en` equals `run` while the trace has not ended, whatever the sub-switch state.
- R5: A trigger is taken in a cycle with `run` high, the trace not ended, `mode` not 10, no earlier trigger since arm/clear, and any of these: `addr_hit`, any bit of `data_hit`, `evt_hit`, or a pin edge. The pin edge is taken on a rising edge of `ext_pin` with `ext_sel`=01, on a falling edge with `ext_sel`=10, and never with 00 or 11. The previous pin value is registered and reads 0 after reset.
- R6: After a trigger, the trigger cycle (if it captures) and the following capture cycles are counted. The counter advances only in cycles where `cap_en` is high. The capture cycle at count `delay` is the last one, and `ended` rises in the next cycle. A `delay` of 0 makes a capturing trigger cycle the last captured cycle.
- R7: Once `ended` is high, `cap_en` stays low and `ended` stays high until `arm_clr`. This holds even when the start conditions become true again.
- R8: In forced-delay mode (`mode`=10), triggers are ignored and `cap_en` equals `run`. Every capture cycle is counted from arm/clear, so `delay`+1 cycles are captured before `ended` rises.
- R9: `trig_n` is low for exactly the one cycle that follows the cycle in which a trigger is taken, and high otherwise.
- R10: `arm_clr` and reset clear the section flag, the trigger record, the counter and `ended`. `trig_n` is high out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_clr | input | 1 | Synchronous re-arm of flag, trigger, counter and ended status |
| run | input | 1 | Processor executing |
| mode | input | 2 | 00/11 gated, 01 forced start, 10 forced delay |
| comb_and | input | 1 | Sub-switch combine: 0 OR, 1 AND |
| cap_on | input | 1 | Capture while sub-switch on |
| cap_off | input | 1 | Capture while sub-switch off |
| sec_on_ev | input | 1 | Section-on event strobe |
| sec_off_ev | input | 1 | Section-off event strobe |
| qual_ev | input | 1 | Qualify event strobe |
| addr_hit | input | 1 | Execution-address match |
| data_hit | input | NCH | Data-compare channel matches |
| evt_hit | input | 1 | Event-match trigger strobe |
| ext_pin | input | 1 | External trigger pin (synchronous) |
| ext_sel | input | 2 | Pin condition: 00 off, 01 rising, 10 falling, 11 off |
| delay | input | CW | Post-trigger capture count |
| cap_en | output | 1 | Capture trace data this cycle |
| ended | output | 1 | Trace terminated |
| trig_n | output | 1 | Active-low trigger pulse |

## Verification
The bench builds the block with its defaults, four data-compare channels and a 17-bit counter. Every configuration of mode, combine, policy and pin selection can then be swept. Delays of 0, 1, a few cycles and several hundred are used. The small delays put the same-cycle ending and the pause of the counter during stopped cycles in reach. The long delay makes the counter carry through many bits while the sub-switch pauses it again and again.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    MODE_GATED  = 2'b00,
    MODE_FSTART = 2'b01,
    MODE_FDELAY = 2'b10,
    MODE_GATED2 = 2'b11
  } trc_mode_e;

  typedef enum logic [1:0] {
    PIN_OFF  = 2'b00,
    PIN_RISE = 2'b01,
    PIN_FALL = 2'b10,
    PIN_OFF2 = 2'b11
  } pin_sel_e;

  // sub-switch combination of flag and qualify event
  function automatic logic sw_combine(input logic flag, input logic qual, input logic use_and);
    return use_and ? (flag & qual) : (flag | qual);
  endfunction

  // capture policy for a given sub-switch state
  function automatic logic policy_pick(input logic sw, input logic on_ok, input logic off_ok);
    return sw ? on_ok : off_ok;
  endfunction

  // pin edge detect per selection
  function automatic logic pin_edge(input logic now, input logic prev, input logic [1:0] sel);
    logic r;
    case (sel)
      PIN_RISE: r = now & ~prev;
      PIN_FALL: r = ~now & prev;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/trc_subswitch.sv
module trc_subswitch
  import trc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sec_on,
  input  logic sec_off,
  input  logic qual,
  input  logic use_and,
  output logic sw_on,
  output logic sec_flag
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (clr)     flag_q <= 1'b0;
    else if (sec_on)  flag_q <= 1'b1;
    else if (sec_off) flag_q <= 1'b0;
  end

  assign sec_flag = flag_q;
  assign sw_on    = sw_combine(flag_q, qual, use_and);

  // R1
  sec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_on && !clr) |=> sec_flag);
  // R1
  sec_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_off && !sec_on && !clr) |=> !sec_flag);
endmodule

// File: rtl/trc_trigger.sv
module trc_trigger
  import trc_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           enable,
  input  logic           addr_hit,
  input  logic [NCH-1:0] data_hit,
  input  logic           evt_hit,
  input  logic           ext_pin,
  input  logic [1:0]     ext_sel,
  output logic           trig_fire,
  output logic           triggered
);
  logic prev_q;
  logic seen_q;
  logic raw_hit;
  logic pin_hit;

  assign pin_hit   = pin_edge(ext_pin, prev_q, ext_sel);
  assign raw_hit   = addr_hit | (|data_hit) | evt_hit | pin_hit;
  assign trig_fire = enable & ~seen_q & ~clr & raw_hit;
  assign triggered = seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= ext_pin;
      if (clr)            seen_q <= 1'b0;
      else if (trig_fire) seen_q <= 1'b1;
    end
  end

  // R5
  single_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fire && !clr) |=> !trig_fire);
endmodule

// File: rtl/trc_delay_ctr.sv
module trc_delay_ctr
  import trc_pkg::*;
#(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          count_en,
  input  logic [CW-1:0] delay,
  output logic          ended,
  output logic          last_cycle
);
  logic [CW-1:0] cnt_q;
  logic          end_q;

  assign last_cycle = count_en & (cnt_q == delay);
  assign ended      = end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      end_q <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      end_q <= 1'b0;
    end else if (last_cycle) begin
      end_q <= 1'b1;
    end else if (count_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !clr) |=> $stable(cnt_q));
  // R6
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cycle && !clr) |=> ended);
endmodule

// File: rtl/trace_gate_seq.sv
module trace_gate_seq
  import trc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm_clr,
  input  logic           run,
  input  logic [1:0]     mode,
  input  logic           comb_and,
  input  logic           cap_on,
  input  logic           cap_off,
  input  logic           sec_on_ev,
  input  logic           sec_off_ev,
  input  logic           qual_ev,
  input  logic           addr_hit,
  input  logic [NCH-1:0] data_hit,
  input  logic           evt_hit,
  input  logic           ext_pin,
  input  logic [1:0]     ext_sel,
  input  logic [CW-1:0]  delay,
  output logic           cap_en,
  output logic           ended,
  output logic           trig_n
);
  logic sw_on, sec_flag;
  logic forced, fdelay;
  logic policy;
  logic trig_en, trig_fire, triggered;
  logic pending, count_en, last_cycle;
  logic trig_n_q;

  assign fdelay = (mode == MODE_FDELAY);
  assign forced = (mode == MODE_FSTART) | fdelay;

  trc_subswitch i_sw (
    .clk(clk), .rst_n(rst_n), .clr(arm_clr),
    .sec_on(sec_on_ev), .sec_off(sec_off_ev), .qual(qual_ev),
    .use_and(comb_and), .sw_on(sw_on), .sec_flag(sec_flag)
  );

  assign policy = forced ? 1'b1 : policy_pick(sw_on, cap_on, cap_off);
  assign cap_en = run & ~ended & policy;

  assign trig_en = run & ~ended & ~fdelay;

  trc_trigger #(.NCH(NCH)) i_trig (
    .clk(clk), .rst_n(rst_n), .clr(arm_clr), .enable(trig_en),
    .addr_hit(addr_hit), .data_hit(data_hit), .evt_hit(evt_hit),
    .ext_pin(ext_pin), .ext_sel(ext_sel),
    .trig_fire(trig_fire), .triggered(triggered)
  );

  assign pending  = triggered | trig_fire | fdelay;
  assign count_en = cap_en & pending;

  trc_delay_ctr #(.CW(CW)) i_dly (
    .clk(clk), .rst_n(rst_n), .clr(arm_clr), .count_en(count_en),
    .delay(delay), .ended(ended), .last_cycle(last_cycle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_n_q <= 1'b1;
    else        trig_n_q <= ~trig_fire;
  end
  assign trig_n = trig_n_q;

  // R9
  trig_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_n |=> trig_n);
  // R7
  no_cap_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ended |-> !cap_en);
  // R7
  end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ended && !arm_clr) |=> ended);
  // R8
  fdelay_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fdelay && $past(fdelay)) |-> trig_n);
  // R10
  clr_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_clr |=> !ended);
endmodule

// File: tb/test_trace_gate_seq.sv
module test_trace_gate_seq;
  localparam int NCH = 4;
  localparam int CW  = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_clr = 0, run = 0, comb_and = 0, cap_on = 1, cap_off = 0;
  logic sec_on_ev = 0, sec_off_ev = 0, qual_ev = 0, addr_hit = 0, evt_hit = 0, ext_pin = 0;
  logic [1:0] mode = 0, ext_sel = 0;
  logic [NCH-1:0] data_hit = 0;
  logic [CW-1:0] delay = 0;
  logic cap_en, ended, trig_n;

  int n_cmp = 0, n_bad = 0;
  // model state
  int m_sec = 0, m_trg = 0, m_cnt = 0, m_term = 0, m_prev = 0, m_tn = 1;

  always #10 clk = ~clk;

  trace_gate_seq #(.NCH(NCH), .CW(CW)) i_trace_gate_seq (
    .clk(clk), .rst_n(rst_n), .arm_clr(arm_clr), .run(run), .mode(mode),
    .comb_and(comb_and), .cap_on(cap_on), .cap_off(cap_off),
    .sec_on_ev(sec_on_ev), .sec_off_ev(sec_off_ev), .qual_ev(qual_ev),
    .addr_hit(addr_hit), .data_hit(data_hit), .evt_hit(evt_hit),
    .ext_pin(ext_pin), .ext_sel(ext_sel), .delay(delay),
    .cap_en(cap_en), .ended(ended), .trig_n(trig_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven at negedge; compare, then advance model
  task automatic cycle();
    int sw, pol, ecap, edge_hit, raw, fire, pend;
    #1;
    if (mode == 2'b01 || mode == 2'b10) pol = 1;
    else begin
      // R2: OR / AND of flag and qualify
      if (comb_and) sw = (m_sec == 1 && qual_ev) ? 1 : 0;
      else          sw = (m_sec == 1 || qual_ev) ? 1 : 0;
      pol = sw ? int'(cap_on) : int'(cap_off);
    end
    ecap = (run && m_term == 0 && pol == 1) ? 1 : 0;
    edge_hit = 0;
    if (ext_sel == 2'b01 && ext_pin && m_prev == 0) edge_hit = 1;
    if (ext_sel == 2'b10 && !ext_pin && m_prev == 1) edge_hit = 1;
    raw = (addr_hit || data_hit != 0 || evt_hit || edge_hit == 1) ? 1 : 0;
    fire = (!arm_clr && run && m_term == 0 && mode != 2'b10 && m_trg == 0 && raw == 1) ? 1 : 0;
    pend = (m_trg == 1 || fire == 1 || mode == 2'b10) ? 1 : 0;

    check("cap_en R1 R2 R3 R4 R7 R8", int'(cap_en), ecap);
    check("ended R6 R7 R8 R10", int'(ended), m_term);
    check("trig_n R5 R9", int'(trig_n), m_tn);

    @(posedge clk);
    m_tn = fire ? 0 : 1;
    m_prev = int'(ext_pin);
    if (arm_clr) begin
      m_sec = 0; m_trg = 0; m_cnt = 0; m_term = 0;
    end else begin
      if (sec_on_ev) m_sec = 1;
      else if (sec_off_ev) m_sec = 0;
      if (fire == 1) m_trg = 1;
      if (ecap == 1 && pend == 1) begin
        if (m_cnt == int'(delay)) m_term = 1;
        else m_cnt++;
      end
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    sec_on_ev = 0; sec_off_ev = 0; qual_ev = 0; addr_hit = 0;
    evt_hit = 0; data_hit = 0; arm_clr = 0;
  endtask

  task automatic rearm();
    quiet();
    arm_clr = 1;
    cycle();
    arm_clr = 0;
  endtask

  task automatic rand_run(input int n, input int trig_rate);
    for (int i = 0; i < n; i++) begin
      run        = ($urandom % 10) != 0;
      sec_on_ev  = ($urandom % 9) == 0;
      sec_off_ev = ($urandom % 9) == 0;
      qual_ev    = ($urandom % 5) == 0;
      addr_hit   = ($urandom % trig_rate) == 0;
      evt_hit    = ($urandom % trig_rate) == 0;
      data_hit   = (($urandom % trig_rate) == 0) ? NCH'(1 << ($urandom % NCH)) : '0;
      ext_pin    = ($urandom % 6) == 0 ? ~ext_pin : ext_pin;
      arm_clr    = ($urandom % 150) == 0;
      cycle();
    end
    quiet();
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R10: reset state
    check("reset ended R10", int'(ended), 0);
    check("reset trig_n R10", int'(trig_n), 1);
    check("reset cap_en R3", int'(cap_en), 0);
    rst_n = 1;
    @(negedge clk);

    // R6: delay 0 in forced start, trigger on a capturing cycle
    mode = 2'b01; delay = 0; rearm();
    run = 1; cycle(); addr_hit = 1; cycle(); addr_hit = 0;
    check("delay0 ended R6", int'(ended), 1);
    check("delay0 cap_en R7", int'(cap_en), 0);
    cycle();

    // R5: pin edges, each selection
    for (int s = 0; s < 4; s++) begin
      mode = 2'b01; delay = 2; ext_sel = 2'(s); rearm(); run = 1;
      for (int k = 0; k < 12; k++) begin
        ext_pin = (k % 4) < 2;
        cycle();
      end
    end
    ext_sel = 0;

    // sweep configurations with random stimulus
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 8; c++) begin
        mode = 2'(m); comb_and = c[0]; cap_on = c[1]; cap_off = c[2];
        ext_sel = 2'(c % 3);
        delay = CW'((c * 3) % 7);
        rearm();
        rand_run(220, 12);
      end

    // long delay: counter carries, paused by sub-switch (R6, R8)
    mode = 2'b00; comb_and = 0; cap_on = 1; cap_off = 0; delay = 300;
    rearm(); rand_run(2500, 40);
    mode = 2'b10; delay = 300;
    rearm(); rand_run(1200, 40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule